// File: doc/BRIEF.md
# Three-Lane PWM Generator with Latched Output Shutdown

This block produces three pulse-width-modulated outputs from one shared up-counter. A period register sets the counter's wrap point. Each lane has its own duty register. At the start of every period each output goes to its inactive level. When the counter reaches the lane's duty value, the output switches to its active level and stays there until the period ends. Each lane selects its own active polarity, and active-low is the reset default.

A pin drives only when both the global drive enable and that pin's own enable are set. An external shutdown input can take away the drive of a chosen subset of pins. The bench treats a pin whose drive enable is low as high impedance. Once a shutdown has taken effect, it stays in force until software issues a clear command while the shutdown input is low.

Sticky match flags record when the counter has hit the period value and each duty value. Software programs the block through a simple write port.

The write-port offsets and bit positions are as follows:

- Address 0 holds the period value, written as (period length − 1).
- Addresses 1, 2 and 3 hold the duty values of lanes 0, 1 and 2. A lane whose duty value is written as D stays inactive for D+1 cycles of each period.
- Address 4 is the control word:
  - bit 0 starts the counter
  - bit 1 is the global drive enable
  - bit 2 arms the shutdown
  - bits 6:4 select active-high polarity per lane
  - bits 10:8 are the per-pin enables
  - bits 14:12 choose which pins the shutdown affects
- Address 5 is a command port:
  - bit 0 requests a shutdown clear
  - bit 1 clears all match flags

Top module: `pwm3_cutoff`

## Requirements
- R1: The first cycle after reset shows `pwm_out` = 0, `pwm_oe` = 0 and `match_flag` = 0.
- R2: For a period value P, the counter counts 0..P and then wraps to 0. Every output therefore repeats with a period of P+1 cycles.
- R3: A lane with duty value D < P is inactive for D+1 cycles at the start of each period. It is active for the remaining P−D cycles.
- R4: A lane's active level is high when its polarity bit (control bits 6:4) is 1, and low when the bit is 0. The reset default is 0, which makes the lane active-low.
- R5: In the cycle where `match_flag[0]` first shows a new period match, every output is at its inactive level.
- R6: A duty value greater than or equal to P keeps that lane inactive for the whole period.
- R7: While the counter is stopped (control bit 0 = 0), every output is held low from the next cycle on.
- R8: `pwm_oe[i]` is 1 only when the global enable (control bit 1) and pin enable i (control bit 8+i) are both 1. This takes effect one cycle after the write.
- R9: While the shutdown is armed (control bit 2), a high `cut_in` clears `pwm_oe` of the selected pins (control bits 14:12) one cycle later. Unselected pins are unaffected, and a high `cut_in` has no effect while the shutdown is not armed.
- R10: A shutdown stays in force after `cut_in` falls. A clear command (address 5, bit 0) ends it only if `cut_in` is low in that cycle.
- R11: `match_flag[0]` sets when the counter equals P. `match_flag[1+i]` sets when the counter equals duty value i while running. The flags stay set until a flag-clear command (address 5, bit 1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| cut_in | input | 1 | External shutdown request |
| pwm_out | output | 3 | Output levels, one per lane |
| pwm_oe | output | 3 | Drive enable per pin; 0 means high impedance |
| match_flag | output | 4 | Sticky flags: bit 0 period, bits 3:1 lanes 0..2 |

## Verification
A register write lands on the clock edge that samples it. Anything derived from that register (output level, drive enable, run state) follows one edge later. The bench therefore samples on the second falling edge after it starts a write. A `cut_in` change and a clear command act on drive enables within a single edge, so those checks sample on the very next falling edge. The bench measures duty and period by counting active cycles over whole periods, after a settling gap. Those checks are therefore independent of counter phase. The period-start check polls for the flag and checks the outputs in the same cycle that the flag appears.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;
  localparam int ADDR_W   = 3;
  localparam int REG_PER  = 0;
  localparam int REG_DUTY = 1;
  localparam int REG_CTL  = 4;
  localparam int REG_CMD  = 5;
  localparam int CTL_RUN  = 0;
  localparam int CTL_GEN  = 1;
  localparam int CTL_ARM  = 2;
  localparam int CTL_POL  = 4;
  localparam int CTL_PEN  = 8;
  localparam int CTL_SEL  = 12;
  localparam int CMD_CUTCLR  = 0;
  localparam int CMD_FLAGCLR = 1;
endpackage

// File: rtl/pwm3_regs.sv
module pwm3_regs
  import pwm3_pkg::*;
#(
  parameter int W   = 16,
  parameter int NCH = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [W-1:0]            wr_data,
  output logic [W-1:0]            period,
  output logic [NCH-1:0][W-1:0]   duty,
  output logic                    run,
  output logic                    glob_en,
  output logic                    cut_arm,
  output logic [NCH-1:0]          pol,
  output logic [NCH-1:0]          pin_en,
  output logic [NCH-1:0]          cut_sel,
  output logic                    clr_cut,
  output logic                    clr_flag
);
  logic [W-1:0] period_q;
  logic [W-1:0] ctl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      period_q <= '0;
      ctl_q    <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_W'(REG_PER)) period_q <= wr_data;
      if (wr_addr == ADDR_W'(REG_CTL)) ctl_q    <= wr_data;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_duty
    logic [W-1:0] duty_q;
    always_ff @(posedge clk) begin
      if (rst) duty_q <= '0;
      else if (wr_en && wr_addr == ADDR_W'(REG_DUTY + i)) duty_q <= wr_data;
    end
    assign duty[i] = duty_q;
  end

  assign period   = period_q;
  assign run      = ctl_q[CTL_RUN];
  assign glob_en  = ctl_q[CTL_GEN];
  assign cut_arm  = ctl_q[CTL_ARM];
  assign pol      = ctl_q[CTL_POL +: NCH];
  assign pin_en   = ctl_q[CTL_PEN +: NCH];
  assign cut_sel  = ctl_q[CTL_SEL +: NCH];
  assign clr_cut  = wr_en && wr_addr == ADDR_W'(REG_CMD) && wr_data[CMD_CUTCLR];
  assign clr_flag = wr_en && wr_addr == ADDR_W'(REG_CMD) && wr_data[CMD_FLAGCLR];
endmodule

// File: rtl/pwm3_timebase.sv
module pwm3_timebase #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic [W-1:0] period,
  output logic [W-1:0] cnt,
  output logic         wrap,
  output logic         per_match
);
  logic [W-1:0] cnt_q;

  // A period lowered below the running count still wraps at once.
  assign wrap      = run && (cnt_q >= period);
  assign per_match = run && (cnt_q == period);

  always_ff @(posedge clk) begin
    if (rst || !run || wrap) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/pwm3_lane.sv
module pwm3_lane #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         wrap,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] period,
  input  logic [W-1:0] duty,
  input  logic         pol,
  output logic         level,
  output logic         duty_match
);
  logic act_q;
  logic act_nxt;
  logic level_q;

  assign duty_match = run && (cnt == duty);

  always_comb begin
    act_nxt = act_q;
    if (wrap)                                act_nxt = 1'b0;
    else if (duty_match && duty < period)    act_nxt = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      act_q   <= 1'b0;
      level_q <= 1'b0;
    end else begin
      act_q   <= act_nxt;
      level_q <= act_nxt ? pol : ~pol;
    end
  end

  assign level = level_q;
endmodule

// File: rtl/pwm3_cutlatch.sv
module pwm3_cutlatch (
  input  logic clk,
  input  logic rst,
  input  logic cut_in,
  input  logic arm,
  input  logic clr,
  output logic hold,
  output logic hold_nxt
);
  logic hold_q;

  always_comb begin
    hold_nxt = hold_q;
    if (arm && cut_in)      hold_nxt = 1'b1;
    else if (clr && !cut_in) hold_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) hold_q <= 1'b0;
    else     hold_q <= hold_nxt;
  end

  assign hold = hold_q;
endmodule

// File: rtl/pwm3_cutoff.sv
module pwm3_cutoff
  import pwm3_pkg::*;
#(
  parameter int W   = 16,
  parameter int NCH = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  input  logic              cut_in,
  output logic [NCH-1:0]    pwm_out,
  output logic [NCH-1:0]    pwm_oe,
  output logic [NCH:0]      match_flag
);
  logic [W-1:0]          period;
  logic [NCH-1:0][W-1:0] duty;
  logic                  run, glob_en, cut_arm, clr_cut, clr_flag;
  logic [NCH-1:0]        pol, pin_en, cut_sel;
  logic [W-1:0]          cnt;
  logic                  wrap, per_match;
  logic [NCH-1:0]        lvl, dmatch;
  logic                  cut_hold, cut_hold_nxt;
  logic [NCH-1:0]        oe_q;
  logic [NCH:0]          flag_q;

  pwm3_regs #(.W(W), .NCH(NCH)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .period(period), .duty(duty), .run(run), .glob_en(glob_en),
    .cut_arm(cut_arm), .pol(pol), .pin_en(pin_en), .cut_sel(cut_sel),
    .clr_cut(clr_cut), .clr_flag(clr_flag)
  );

  pwm3_timebase #(.W(W)) u_tb (
    .clk(clk), .rst(rst), .run(run), .period(period),
    .cnt(cnt), .wrap(wrap), .per_match(per_match)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_lane
    pwm3_lane #(.W(W)) u_lane (
      .clk(clk), .rst(rst), .run(run), .wrap(wrap), .cnt(cnt),
      .period(period), .duty(duty[i]), .pol(pol[i]),
      .level(lvl[i]), .duty_match(dmatch[i])
    );
  end

  pwm3_cutlatch u_cut (
    .clk(clk), .rst(rst), .cut_in(cut_in), .arm(cut_arm), .clr(clr_cut),
    .hold(cut_hold), .hold_nxt(cut_hold_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q   <= '0;
      flag_q <= '0;
    end else begin
      oe_q   <= {NCH{glob_en}} & pin_en & ~({NCH{cut_hold_nxt}} & cut_sel);
      flag_q <= (clr_flag ? '0 : flag_q) | {dmatch, per_match};
    end
  end

  assign pwm_out    = lvl;
  assign pwm_oe     = oe_q;
  assign match_flag = flag_q;
endmodule

// File: rtl/pwm3_chk.sv
module pwm3_chk #(
  parameter int W   = 16,
  parameter int NCH = 3
) (
  input logic           clk,
  input logic           rst,
  input logic           run,
  input logic [W-1:0]   cnt,
  input logic [W-1:0]   period,
  input logic           glob_en,
  input logic [NCH-1:0] cut_sel,
  input logic           cut_hold,
  input logic           cut_hold_nxt,
  input logic           clr_cut,
  input logic           clr_flag,
  input logic           cut_in,
  input logic [NCH-1:0] pwm_out,
  input logic [NCH-1:0] pwm_oe,
  input logic [NCH:0]   match_flag
);
  // R2: a count at or past the period returns to zero
  p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (run && cnt >= period) |=> cnt == '0);

  // R7: stopped counter forces outputs low
  p_stop_low_r7: assert property (@(posedge clk) disable iff (rst)
    !run |=> pwm_out == '0);

  // R8: no drive without the global enable
  p_gen_gate_r8: assert property (@(posedge clk) disable iff (rst)
    !glob_en |=> pwm_oe == '0);

  // R9: a pending shutdown removes drive of selected pins
  p_cut_oe_r9: assert property (@(posedge clk) disable iff (rst)
    cut_hold_nxt |=> (pwm_oe & $past(cut_sel)) == '0);

  // R10: shutdown ends only on a clear with the input low
  p_cut_release_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(cut_hold) |-> $past(clr_cut && !cut_in));

  // R11: flags stay set until cleared
  p_flag_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    !clr_flag |=> (match_flag & $past(match_flag)) == $past(match_flag));
endmodule

bind pwm3_cutoff pwm3_chk #(.W(W), .NCH(NCH)) u_chk (
  .clk(clk), .rst(rst), .run(run), .cnt(cnt), .period(period),
  .glob_en(glob_en), .cut_sel(cut_sel), .cut_hold(cut_hold),
  .cut_hold_nxt(cut_hold_nxt), .clr_cut(clr_cut), .clr_flag(clr_flag),
  .cut_in(cut_in), .pwm_out(pwm_out), .pwm_oe(pwm_oe), .match_flag(match_flag)
);

// File: tb/tb_pwm3_cutoff.sv
module tb_pwm3_cutoff;
  localparam int W = 16;
  localparam int NCH = 3;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           wr_en = 1'b0;
  logic [2:0]     wr_addr = '0;
  logic [W-1:0]   wr_data = '0;
  logic           cut_in = 1'b0;
  logic [NCH-1:0] pwm_out, pwm_oe;
  logic [NCH:0]   match_flag;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  pwm3_cutoff #(.W(W), .NCH(NCH)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cut_in(cut_in), .pwm_out(pwm_out), .pwm_oe(pwm_oe), .match_flag(match_flag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(addr); wr_data = W'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic int ctl(input int run, input int gen, input int arm,
                             input int pol, input int pen, input int sel);
    return run | (gen << 1) | (arm << 2) | (pol << 4) | (pen << 8) | (sel << 12);
  endfunction

  function automatic int exp_active(input int p, input int d, input int nper);
    return (d >= p) ? 0 : (p - d) * nper;
  endfunction

  task automatic count_active(input int cycles, input logic [NCH-1:0] pol,
                              output int cnt0, output int cnt1, output int cnt2);
    cnt0 = 0; cnt1 = 0; cnt2 = 0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      if (pwm_out[0] == pol[0]) cnt0++;
      if (pwm_out[1] == pol[1]) cnt1++;
      if (pwm_out[2] == pol[2]) cnt2++;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(pwm_out == '0, "R1 out", int'(pwm_out), 0);
    chk(pwm_oe == '0, "R1 oe", int'(pwm_oe), 0);
    chk(match_flag == '0, "R1 flags", int'(match_flag), 0);
  endtask

  task automatic t_basic();
    int a0, a1, a2, last, gap, prev;
    wr(0, 9); wr(1, 1); wr(2, 4); wr(3, 7);
    wr(4, ctl(1, 1, 0, 0, 7, 0));
    repeat (4) @(negedge clk);
    count_active(20, 3'b000, a0, a1, a2);
    chk(a0 == exp_active(9, 1, 2), "R3 lane0 active", a0, exp_active(9, 1, 2));
    chk(a1 == exp_active(9, 4, 2), "R3 lane1 active", a1, exp_active(9, 4, 2));
    chk(a2 == exp_active(9, 7, 2), "R4 active-low lane2", a2, exp_active(9, 7, 2));
    chk(pwm_oe == 3'b111, "R8 both enables", int'(pwm_oe), 7);
    last = -1; gap = -1; prev = pwm_out[0];
    for (int k = 0; k < 30 && gap < 0; k++) begin
      @(negedge clk);
      if (prev == 1 && pwm_out[0] == 0) begin
        if (last >= 0) gap = k - last;
        last = k;
      end
      prev = pwm_out[0];
    end
    chk(gap == 10, "R2 period length", gap, 10);
  endtask

  task automatic t_period_start();
    bit seen = 0;
    wr(5, 2);
    for (int k = 0; k < 30 && !seen; k++) begin
      @(negedge clk);
      if (match_flag[0]) begin
        seen = 1;
        chk(pwm_out == 3'b111, "R5 inactive at period start", int'(pwm_out), 7);
      end
    end
    chk(seen, "R11 period flag", int'(seen), 1);
    repeat (11) @(negedge clk);
    chk(match_flag == 4'b1111, "R11 all flags", int'(match_flag), 15);
  endtask

  task automatic t_stop_edges();
    int a0, a1, a2;
    wr(4, ctl(0, 1, 0, 0, 7, 0));
    @(negedge clk);
    chk(pwm_out == '0, "R7 stopped low", int'(pwm_out), 0);
    wr(5, 2);
    chk(match_flag == '0, "R11 clear", int'(match_flag), 0);
    wr(1, 9); wr(2, 12); wr(3, 0);
    wr(4, ctl(1, 1, 0, 7, 7, 0));
    repeat (4) @(negedge clk);
    count_active(20, 3'b111, a0, a1, a2);
    chk(a0 == 0, "R6 duty equal period", a0, 0);
    chk(a1 == 0, "R6 duty above period", a1, 0);
    chk(a2 == exp_active(9, 0, 2), "R4 active-high lane2", a2, exp_active(9, 0, 2));
    wr(5, 2);
    repeat (12) @(negedge clk);
    chk(match_flag[1] == 1'b1, "R11 flag at duty==period", int'(match_flag[1]), 1);
    chk(match_flag[2] == 1'b0, "R11 no flag above period", int'(match_flag[2]), 0);
  endtask

  task automatic t_enable();
    wr(4, ctl(1, 0, 0, 0, 7, 0));
    @(negedge clk);
    chk(pwm_oe == '0, "R8 global off", int'(pwm_oe), 0);
    wr(4, ctl(1, 1, 0, 0, 5, 0));
    @(negedge clk);
    chk(pwm_oe == 3'b101, "R8 pin mask", int'(pwm_oe), 5);
  endtask

  task automatic t_cutoff();
    wr(4, ctl(1, 1, 0, 0, 7, 3));
    @(negedge clk);
    cut_in = 1'b1;
    @(negedge clk);
    chk(pwm_oe == 3'b111, "R9 unarmed ignored", int'(pwm_oe), 7);
    cut_in = 1'b0;
    wr(4, ctl(1, 1, 1, 0, 7, 3));
    @(negedge clk);
    chk(pwm_oe == 3'b111, "R9 armed idle", int'(pwm_oe), 7);
    cut_in = 1'b1;
    @(negedge clk);
    chk(pwm_oe == 3'b100, "R9 selected pins off", int'(pwm_oe), 4);
    cut_in = 1'b0;
    repeat (3) @(negedge clk);
    chk(pwm_oe == 3'b100, "R10 held after release", int'(pwm_oe), 4);
    cut_in = 1'b1;
    wr(5, 1);
    chk(pwm_oe == 3'b100, "R10 clear while high", int'(pwm_oe), 4);
    cut_in = 1'b0;
    @(negedge clk);
    chk(pwm_oe == 3'b100, "R10 still held", int'(pwm_oe), 4);
    wr(5, 1);
    chk(pwm_oe == 3'b111, "R10 cleared", int'(pwm_oe), 7);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 20000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic();
    t_period_start();
    t_stop_edges();
    t_enable();
    t_cutoff();
    finish_run();
  end
endmodule